// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames from a byte stream and spreads them over a ring of receive buffer descriptors held in system memory. Each descriptor is eight bytes and sits at a fixed stride. Its 16-bit flag word carries an empty bit owned by software, a wrap bit that closes the ring, and the status bits that the block fills in. The block reads a descriptor's flags and buffer address, writes frame bytes into that buffer, and writes the flags and a length back. It then steps to the next descriptor.

A CRC-32 is computed while the bytes stream in and is stored after the payload. The appended CRC counts toward the frame length. Two length limits apply:
- A hard maximum truncates the frame.
- A software limit only flags the frame as too long.

Receive stays active only while the descriptor under the ring pointer is empty. Software re-arms receive with a demand pulse.

The input byte stream is valid/ready. While receive is inactive in the idle state, `s_ready` stays low and frames wait upstream. During descriptor fetch and write-back, `s_ready` is also low. While a byte is being stored, `s_ready` follows `wr_ready`. Once the sender raises `s_valid`, it must hold `s_valid`, `s_data` and `s_last` until the byte is taken. The buffer write port and the descriptor write-back port are also valid/ready. Each holds its request stable until it is accepted. A descriptor read returns flags and buffer address in the cycle after `desc_rd_req`.

Top module: `rxbd_writer`

## Requirements
- R1: After reset, `rx_active`, `s_ready`, `wr_valid`, `desc_wr_valid`, both event pulses and `demand_status` are all zero.
- R2: A `rx_demand` pulse in idle, with `enable` high and receive inactive, reads the descriptor at the ring pointer and sets `rx_active` to its empty bit (bit 15). When `enable` is low, the pulse has no effect. A low `enable` clears `rx_active` on the next cycle. `demand_status` shows `rx_active` in bit 24 and zero elsewhere.
- R3: After the payload, four CRC bytes are stored, most significant byte first. The CRC is the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, final inversion) over every payload byte received, including bytes dropped by truncation. The stored length includes these four bytes.
- R4: The usable buffer size is `buf_size_cfg` with only bits 10:4 kept. Each descriptor receives up to that many bytes, and its length field holds the number of bytes placed in it.
- R5: A written-back descriptor has the empty bit (15) cleared and its other flag bits kept. The final descriptor of a frame also gets the last bit (11).
- R6: When the stored length including the CRC exceeds `frame_limit`, the final descriptor gets the too-long bit (5). The whole frame is still stored.
- R7: When payload plus CRC would exceed `MAX_FRAME`, only `MAX_FRAME-4` payload bytes are stored, followed by the CRC. The final descriptor then gets both the truncated bit (0) and the too-long bit (5).
- R8: When the next descriptor is not empty in the middle of a frame, the rest of the frame is taken from the stream and discarded. No final descriptor is written, no frame event fires, and `rx_active` drops.
- R9: `ring_load` in idle sets the ring pointer and the ring start to `ring_base`. After each write-back, the pointer moves ahead 8 bytes, or back to the ring start when the descriptor's wrap bit (13) is set.
- R10: After a completed frame, `rx_active` equals the empty bit of the descriptor now under the pointer.
- R11: `ev_buf_done` pulses once for each accepted descriptor write-back. `ev_frame_done` pulses only with the write-back of a final descriptor.
- R12: While receive is inactive in idle, `s_ready` stays low. A buffer write or descriptor write-back that is stalled keeps its address and data until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Controller enabled |
| rx_demand | input | 1 | Receive-demand pulse |
| ring_load | input | 1 | Load ring start and pointer |
| ring_base | input | AW | Ring start address |
| buf_size_cfg | input | LW | Buffer size setting (bits 10:4 used) |
| frame_limit | input | LW | Software frame length limit |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of frame |
| desc_rd_req | output | 1 | Descriptor read request |
| desc_rd_addr | output | AW | Descriptor read address |
| desc_rd_flags | input | 16 | Descriptor flags, one cycle after request |
| desc_rd_buf | input | AW | Descriptor buffer address, one cycle after request |
| wr_valid | output | 1 | Buffer byte write valid |
| wr_ready | input | 1 | Buffer byte write accepted |
| wr_addr | output | AW | Buffer byte address |
| wr_data | output | 8 | Buffer byte data |
| desc_wr_valid | output | 1 | Descriptor write-back valid |
| desc_wr_ready | input | 1 | Descriptor write-back accepted |
| desc_wr_addr | output | AW | Descriptor write-back address |
| desc_wr_flags | output | 16 | Flags written back |
| desc_wr_len | output | LW | Length written back |
| ev_buf_done | output | 1 | Buffer done event |
| ev_frame_done | output | 1 | Frame done event |
| rx_active | output | 1 | Receive active |
| demand_status | output | 32 | Receive-demand readback, bit 24 active |

## Verification
The bench aims at the points where a buffer boundary meets the CRC.

- **Payload fills a buffer exactly.** The CRC must go alone into a fresh descriptor. A design that closed the buffer late, or marked it last, would show a wrong length or a missing write-back.
- **Payload plus CRC fills a buffer exactly.** That descriptor is the final one. A design that opened one more descriptor would use up an extra ring entry.
- **Truncation.** Truncation must still give a CRC over the dropped bytes and set both error bits.
- **Software limit.** Exceeding the software limit must store the whole frame. A design that mixed up the two limits would cut the frame short or miss the too-long bit.
- **Drop in mid-frame.** A non-empty descriptor met partway through a frame must consume the tail without a frame event.
- **Wrap.** The pointer must return to the ring start at the wrap bit. A wrong wrap shows up at once as a write-back address off the ring.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  // flag bit positions decoded by software in the descriptor
  localparam int FLG_EMPTY = 15;
  localparam int FLG_WRAP  = 13;
  localparam int FLG_LAST  = 11;
  localparam int FLG_LONG  = 5;
  localparam int FLG_TRUNC = 0;

  localparam logic [15:0] BUF_SIZE_MASK = 16'h07F0;
  localparam int          DESC_STRIDE   = 8;
  localparam int          CRC_BYTES     = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_CAP, ST_DATA, ST_CRC, ST_WB, ST_ADV, ST_DROP
  } wr_state_t;

  // what a descriptor fetch is for
  typedef enum logic [1:0] {
    FP_ARM, FP_DATA, FP_CRC
  } fetch_purpose_t;
endpackage

// File: rtl/rxbd_crc32.sv
module rxbd_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [31:0] crc_out
);
  localparam logic [31:0] POLY_REFL = 32'hEDB88320;

  logic [31:0] state_q;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= '1;
    else if (init) state_q <= '1;
    else if (en)   state_q <= crc_step(state_q, data);
  end

  assign crc_out = ~state_q;
endmodule

// File: rtl/rxbd_ring_ptr.sv
module rxbd_ring_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  import rxbd_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(DESC_STRIDE);

  logic [AW-1:0] start_q;
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      ptr_q   <= '0;
    end else if (load) begin
      start_q <= base;
      ptr_q   <= base;
    end else if (adv) begin
      ptr_q <= wrap ? start_q : (ptr_q + STEP);
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/rxbd_writer.sv
module rxbd_writer #(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int MAX_FRAME = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          rx_demand,
  input  logic          ring_load,
  input  logic [AW-1:0] ring_base,
  input  logic [LW-1:0] buf_size_cfg,
  input  logic [LW-1:0] frame_limit,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          desc_rd_req,
  output logic [AW-1:0] desc_rd_addr,
  input  logic [15:0]   desc_rd_flags,
  input  logic [AW-1:0] desc_rd_buf,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          desc_wr_valid,
  input  logic          desc_wr_ready,
  output logic [AW-1:0] desc_wr_addr,
  output logic [15:0]   desc_wr_flags,
  output logic [LW-1:0] desc_wr_len,
  output logic          ev_buf_done,
  output logic          ev_frame_done,
  output logic          rx_active,
  output logic [31:0]   demand_status
);
  import rxbd_pkg::*;

  localparam int            PAY_CAP  = MAX_FRAME - CRC_BYTES;
  localparam logic [LW-1:0] CAP_V    = LW'(PAY_CAP);
  localparam logic [LW-1:0] BMASK    = LW'(BUF_SIZE_MASK);
  localparam logic [LW-1:0] ONE      = LW'(1);
  localparam int            STAT_BIT = 24;

  wr_state_t      state_q;
  fetch_purpose_t purpose_q;
  logic [AW-1:0]  buf_q;
  logic [15:0]    flags_q;
  logic [LW-1:0]  cnt_q;
  logic [LW-1:0]  pay_q;
  logic [LW-1:0]  total_q;
  logic           tr_q;
  logic           last_q;
  logic [1:0]     crc_idx_q;
  logic           active_q;

  logic [LW-1:0]  bsz;
  logic           store;
  logic           in_fire;
  logic           wr_fire;
  logic           wb_fire;
  logic           buf_full_next;
  logic           frame_start;
  logic           too_long;
  logic [31:0]    crc_val;
  logic [7:0]     crc_byte;
  logic [AW-1:0]  ptr;

  assign bsz           = buf_size_cfg & BMASK;
  assign store         = (pay_q < CAP_V);
  assign in_fire       = s_valid & s_ready;
  assign wr_fire       = wr_valid & wr_ready;
  assign wb_fire       = desc_wr_valid & desc_wr_ready;
  assign buf_full_next = ((cnt_q + ONE) == bsz);
  assign frame_start   = (state_q == ST_IDLE) && active_q && s_valid &&
                         !(enable && rx_demand && !active_q);
  assign too_long      = tr_q | (total_q > frame_limit);

  // CRC engine sees every payload byte, stored or dropped
  rxbd_crc32 u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (frame_start),
    .en      ((state_q == ST_DATA) && in_fire),
    .data    (s_data),
    .crc_out (crc_val)
  );

  rxbd_ring_ptr #(.AW(AW)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ring_load && (state_q == ST_IDLE)),
    .base  (ring_base),
    .adv   (state_q == ST_ADV),
    .wrap  (flags_q[FLG_WRAP]),
    .ptr   (ptr)
  );

  // CRC goes out most significant byte first
  always_comb begin
    case (crc_idx_q)
      2'd0:    crc_byte = crc_val[31:24];
      2'd1:    crc_byte = crc_val[23:16];
      2'd2:    crc_byte = crc_val[15:8];
      default: crc_byte = crc_val[7:0];
    endcase
  end

  always_comb begin
    s_ready       = 1'b0;
    wr_valid      = 1'b0;
    wr_data       = s_data;
    desc_rd_req   = 1'b0;
    desc_wr_valid = 1'b0;
    case (state_q)
      ST_RD:   desc_rd_req = 1'b1;
      ST_DATA: begin
        if (store) begin
          wr_valid = s_valid;
          s_ready  = wr_ready;
        end else begin
          s_ready  = 1'b1;
        end
      end
      ST_CRC: begin
        wr_valid = 1'b1;
        wr_data  = crc_byte;
      end
      ST_WB:   desc_wr_valid = 1'b1;
      ST_DROP: s_ready = 1'b1;
      default: ;
    endcase
  end

  assign wr_addr      = buf_q + AW'(cnt_q);
  assign desc_rd_addr = ptr;
  assign desc_wr_addr = ptr;
  assign desc_wr_len  = cnt_q;

  always_comb begin
    desc_wr_flags            = flags_q;
    desc_wr_flags[FLG_EMPTY] = 1'b0;
    if (last_q) begin
      desc_wr_flags[FLG_LAST] = 1'b1;
      if (tr_q)     desc_wr_flags[FLG_TRUNC] = 1'b1;
      if (too_long) desc_wr_flags[FLG_LONG]  = 1'b1;
    end
  end

  assign ev_buf_done   = wb_fire;
  assign ev_frame_done = wb_fire & last_q;
  assign rx_active     = active_q;

  always_comb begin
    demand_status           = '0;
    demand_status[STAT_BIT] = active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      purpose_q <= FP_ARM;
      buf_q     <= '0;
      flags_q   <= '0;
      cnt_q     <= '0;
      pay_q     <= '0;
      total_q   <= '0;
      tr_q      <= 1'b0;
      last_q    <= 1'b0;
      crc_idx_q <= '0;
      active_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (enable && rx_demand && !active_q) begin
            purpose_q <= FP_ARM;
            state_q   <= ST_RD;
          end else if (frame_start) begin
            purpose_q <= FP_DATA;
            pay_q     <= '0;
            total_q   <= '0;
            tr_q      <= 1'b0;
            last_q    <= 1'b0;
            crc_idx_q <= '0;
            state_q   <= ST_RD;
          end
        end
        ST_RD: state_q <= ST_CAP;
        ST_CAP: begin
          if (purpose_q == FP_ARM) begin
            active_q <= desc_rd_flags[FLG_EMPTY];
            state_q  <= ST_IDLE;
          end else if (desc_rd_flags[FLG_EMPTY]) begin
            flags_q <= desc_rd_flags;
            buf_q   <= desc_rd_buf;
            cnt_q   <= '0;
            state_q <= (purpose_q == FP_CRC) ? ST_CRC : ST_DATA;
          end else begin
            // ring exhausted mid-frame: discard the remainder
            active_q <= 1'b0;
            state_q  <= (purpose_q == FP_CRC) ? ST_IDLE : ST_DROP;
          end
        end
        ST_DATA: begin
          if (in_fire) begin
            if (store) begin
              cnt_q   <= cnt_q + ONE;
              pay_q   <= pay_q + ONE;
              total_q <= total_q + ONE;
            end else begin
              tr_q <= 1'b1;
            end
            if (store && buf_full_next) begin
              last_q    <= 1'b0;
              purpose_q <= s_last ? FP_CRC : FP_DATA;
              state_q   <= ST_WB;
            end else if (s_last) begin
              state_q <= ST_CRC;
            end
          end
        end
        ST_CRC: begin
          if (wr_fire) begin
            cnt_q     <= cnt_q + ONE;
            total_q   <= total_q + ONE;
            crc_idx_q <= crc_idx_q + 2'd1;
            if (crc_idx_q == 2'd3) begin
              last_q  <= 1'b1;
              state_q <= ST_WB;
            end else if (buf_full_next) begin
              last_q    <= 1'b0;
              purpose_q <= FP_CRC;
              state_q   <= ST_WB;
            end
          end
        end
        ST_WB: begin
          if (wb_fire) state_q <= ST_ADV;
        end
        ST_ADV: begin
          if (last_q) purpose_q <= FP_ARM;
          state_q <= ST_RD;
        end
        ST_DROP: begin
          if (in_fire && s_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (!enable) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rxbd_writer_sva.sv
module rxbd_writer_sva #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          rx_active,
  input logic [LW-1:0] buf_size_cfg,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          desc_wr_valid,
  input logic          desc_wr_ready,
  input logic [AW-1:0] desc_wr_addr,
  input logic [15:0]   desc_wr_flags,
  input logic [LW-1:0] desc_wr_len,
  input logic          ev_buf_done,
  input logic          ev_frame_done
);
  logic [LW-1:0] bsz_chk;
  assign bsz_chk = buf_size_cfg & LW'(16'h07F0);

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !rx_active); // R2

  AST_LEN_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_valid |-> (desc_wr_len != '0) && ((bsz_chk == '0) || (desc_wr_len <= bsz_chk))); // R4

  AST_EMPTY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr_valid |-> !desc_wr_flags[15]); // R5

  AST_TRUNC_IS_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr_valid && desc_wr_flags[0]) |-> (desc_wr_flags[5] && desc_wr_flags[11])); // R7

  AST_FRAME_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_done |-> (ev_buf_done && desc_wr_flags[11])); // R11

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R12

  AST_DESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr_valid && !desc_wr_ready) |=>
      (desc_wr_valid && $stable(desc_wr_addr) && $stable(desc_wr_flags) && $stable(desc_wr_len))); // R12
endmodule

bind rxbd_writer rxbd_writer_sva #(.AW(AW), .LW(LW)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .rx_active     (rx_active),
  .buf_size_cfg  (buf_size_cfg),
  .wr_valid      (wr_valid),
  .wr_ready      (wr_ready),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .desc_wr_valid (desc_wr_valid),
  .desc_wr_ready (desc_wr_ready),
  .desc_wr_addr  (desc_wr_addr),
  .desc_wr_flags (desc_wr_flags),
  .desc_wr_len   (desc_wr_len),
  .ev_buf_done   (ev_buf_done),
  .ev_frame_done (ev_frame_done)
);

// File: tb/rxbd_writer_tb.sv
module rxbd_writer_tb;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int MAXF = 40;
  localparam int CAP = MAXF - 4;
  localparam logic [31:0] RING = 32'h1000;
  localparam logic [31:0] BUFB = 32'h8000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, enable, rx_demand, ring_load;
  logic [AW-1:0] ring_base;
  logic [LW-1:0] buf_size_cfg, frame_limit;
  logic s_valid, s_ready, s_last;
  logic [7:0] s_data;
  logic desc_rd_req;
  logic [AW-1:0] desc_rd_addr, desc_rd_buf;
  logic [15:0] desc_rd_flags;
  logic wr_valid, wr_ready;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic desc_wr_valid, desc_wr_ready;
  logic [AW-1:0] desc_wr_addr;
  logic [15:0] desc_wr_flags;
  logic [LW-1:0] desc_wr_len;
  logic ev_buf_done, ev_frame_done, rx_active;
  logic [31:0] demand_status;

  rxbd_writer #(.AW(AW), .LW(LW), .MAX_FRAME(MAXF)) u_dut (.*);

  int checks = 0;
  int errors = 0;
  logic [15:0] mem_flags [4];
  logic [39:0] exp_wr [$];
  logic [63:0] exp_desc [$];
  logic [7:0]  frame_q [$];
  int m_idx = 0;
  int exp_frames = 0;
  int seen_frames = 0;
  int bsz_model = 16;
  logic exp_active = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ frame_q[i][b]) c = (c >> 1) ^ 32'hEDB88320;
        else                      c = c >> 1;
      end
    end
    return ~c;
  endfunction

  // memory and port monitor: drive ready at negedge, sample 1 ns later
  always begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready = lfsr[0] | lfsr[3];
    desc_wr_ready = lfsr[5] | lfsr[1];
    #1;
    if (rst_n) begin
      if (wr_valid && wr_ready) begin
        if (exp_wr.size() == 0) check(0, "R3 R4 unexpected byte write", {24'h0, wr_addr, wr_data}, 0);
        else begin
          logic [39:0] e;
          e = exp_wr.pop_front();
          check({wr_addr, wr_data} == e, "R3 R4 byte write", {24'h0, wr_addr, wr_data}, {24'h0, e});
        end
      end
      if (desc_wr_valid && desc_wr_ready) begin
        int di;
        if (exp_desc.size() == 0) check(0, "R5 R9 unexpected write-back", {desc_wr_addr, desc_wr_flags, desc_wr_len}, 0);
        else begin
          logic [63:0] e;
          e = exp_desc.pop_front();
          check({desc_wr_addr, desc_wr_flags, desc_wr_len} == e, "R5 R6 R7 R9 write-back",
                {desc_wr_addr, desc_wr_flags, desc_wr_len}, e);
        end
        check(ev_frame_done == desc_wr_flags[11], "R11 frame event with last", 64'(ev_frame_done), 64'(desc_wr_flags[11]));
        di = int'((desc_wr_addr - RING) >> 3) & 3;
        mem_flags[di] = desc_wr_flags;
      end
      check(ev_buf_done == (desc_wr_valid && desc_wr_ready), "R11 buffer event", 64'(ev_buf_done),
            64'(desc_wr_valid && desc_wr_ready));
      if (ev_frame_done) seen_frames++;
      if (desc_rd_req) begin
        int ri;
        ri = int'((desc_rd_addr - RING) >> 3) & 3;
        desc_rd_flags = mem_flags[ri];
        desc_rd_buf = BUFB + 32'(ri * 256);
      end
    end
  end

  task automatic refill();
    for (int i = 0; i < 4; i++) mem_flags[i] = 16'h8000 | ((i == 3) ? 16'h2000 : 16'h0);
  endtask

  task automatic demand();
    @(negedge clk); rx_demand = 1'b1;
    @(negedge clk); rx_demand = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic model_frame(input int n);
    logic [15:0] mf [4];
    logic [7:0] bq [$];
    logic [31:0] c;
    logic [15:0] fl;
    int sp, total, rem, k, off;
    bit tr, lg, dropped;
    for (int i = 0; i < 4; i++) mf[i] = mem_flags[i];
    c = ref_crc(n);
    sp = (n < CAP) ? n : CAP;
    total = sp + 4;
    tr = (n > CAP);
    lg = tr || (total > int'(frame_limit));
    for (int i = 0; i < sp; i++) bq.push_back(frame_q[i]);
    bq.push_back(c[31:24]); bq.push_back(c[23:16]); bq.push_back(c[15:8]); bq.push_back(c[7:0]);
    rem = total; off = 0; dropped = 0;
    while (rem > 0) begin
      if (!mf[m_idx][15]) begin dropped = 1; break; end
      k = (rem < bsz_model) ? rem : bsz_model;
      for (int j = 0; j < k; j++) exp_wr.push_back({BUFB + 32'(m_idx * 256 + j), bq[off + j]});
      off += k; rem -= k;
      fl = mf[m_idx] & 16'h7FFF;
      if (rem == 0) fl = fl | 16'h0800 | (tr ? 16'h0001 : 16'h0) | (lg ? 16'h0020 : 16'h0);
      exp_desc.push_back({RING + 32'(m_idx * 8), fl, 16'(k)});
      mf[m_idx] = fl;
      if (fl[13]) m_idx = 0; else m_idx = m_idx + 1;
    end
    if (!dropped) exp_frames++;
    exp_active = dropped ? 1'b0 : mf[m_idx][15];
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = frame_q[i]; s_last = (i == n - 1);
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic run_frame(input int n, input string tag);
    int t;
    frame_q.delete();
    for (int i = 0; i < n; i++) frame_q.push_back(8'(i * 37 + n * 5 + 3));
    model_frame(n);
    send(n);
    t = 0;
    while ((exp_wr.size() != 0 || exp_desc.size() != 0) && t < 3000) begin @(negedge clk); t++; end
    repeat (8) @(negedge clk);
    #1;
    check(exp_wr.size() == 0 && exp_desc.size() == 0, {tag, " all writes seen"},
          64'(exp_wr.size() + exp_desc.size()), 0);
    check(seen_frames == exp_frames, {tag, " R11 frame count"}, 64'(seen_frames), 64'(exp_frames));
    check(rx_active == exp_active, {tag, " R10 active after frame"}, 64'(rx_active), 64'(exp_active));
    check(demand_status == (32'(exp_active) << 24), {tag, " R2 status bit"}, 64'(demand_status), 64'(exp_active) << 24);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; enable = 0; rx_demand = 0; ring_load = 0; ring_base = '0;
    buf_size_cfg = 16'h001F; frame_limit = 16'd64;
    s_valid = 0; s_data = 0; s_last = 0;
    desc_rd_flags = 0; desc_rd_buf = 0; wr_ready = 0; desc_wr_ready = 0;
    refill();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk); #1;
    // R1 reset state
    check(!rx_active && !s_ready && !wr_valid && !desc_wr_valid && !ev_buf_done && !ev_frame_done
          && demand_status == 0, "R1 reset outputs", 64'(demand_status), 0);

    @(negedge clk); ring_base = RING; ring_load = 1;
    @(negedge clk); ring_load = 0;
    demand(); #1;
    check(!rx_active, "R2 demand ignored while disabled", 64'(rx_active), 0);
    enable = 1;
    demand(); #1;
    check(rx_active && demand_status == 32'h0100_0000, "R2 demand arms receive", 64'(demand_status), 64'h0100_0000);

    run_frame(10, "R3 single buffer");
    refill(); demand();
    run_frame(12, "R4 exact fill with CRC");
    refill(); demand();
    run_frame(14, "R9 spill and wrap");
    refill(); demand();
    run_frame(16, "R3 CRC alone in next buffer");
    refill(); demand();
    frame_limit = 16'd20;
    run_frame(20, "R6 over soft limit stored");
    frame_limit = 16'd64;
    refill(); demand();
    run_frame(50, "R7 truncated");

    // R8 next descriptor not empty mid-frame
    refill(); mem_flags[(m_idx + 1) % 4] = mem_flags[(m_idx + 1) % 4] & 16'h7FFF;
    demand();
    run_frame(30, "R8 drop rest");

    // R10 ring full after a good frame, then R12 stream held off
    refill(); demand();
    mem_flags[(m_idx + 1) % 4] = mem_flags[(m_idx + 1) % 4] & 16'h7FFF;
    run_frame(5, "R10 ring full");
    @(negedge clk); s_valid = 1; s_data = 8'h55; s_last = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      check(!s_ready && !wr_valid, "R12 stream held while inactive", 64'(s_ready), 0);
    end
    @(negedge clk); s_valid = 0; s_last = 0;

    // R4 size mask keeps bits 10:4 only
    refill(); demand();
    buf_size_cfg = 16'hF827; bsz_model = 32;
    run_frame(30, "R4 masked size");
    buf_size_cfg = 16'h001F; bsz_model = 16;

    // R2 enable low clears active
    refill(); demand(); #1;
    check(rx_active, "R2 active before disable", 64'(rx_active), 1);
    @(negedge clk); enable = 0;
    @(negedge clk); #1;
    check(!rx_active, "R2 disable clears active", 64'(rx_active), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule